// File: doc/BRIEF.md
# Peripheral Clock Gate and Reset Controller

This controller sits beside a set of peripheral blocks and decides, one bit per block, whether each block's clock runs and whether the block is held in reset. Software drives it through a small register bus. Clock gates are never written directly. A set-strobe register turns gates on and a clear-strobe register turns them off, so a bit that software leaves at 0 is never disturbed. Reset lines are held in a plain read/write register. A parameter marks which blocks have a gate and which have a reset line. A block without a gate always runs. A block without a reset line is never held in reset.

A clock control register carries a PLL performance-mode code and the controls for a shared 26 MHz oscillator. Two audio consumers each have a select bit that routes the oscillator to them. The oscillator stays powered while any consumer selects it, even when a write clears its own enable bit. Every write to the clock control register drops the PLL lock flag in the status register for a fixed, parameterised number of cycles. Software polls that flag before it relies on the new mode.

Top module: `ckrst_ctrl`

## Requirements
- R1: After reset, `blk_clk_en` equals ALWAYS_ON_MASK OR'd with the blocks that have no gate (0x0081 by default). `blk_rst` equals RST_CAP_MASK with the ALWAYS_ON_MASK bits cleared (0xBFFE). `osc_en`, `aud_osc_sel` and `perf_mode` are 0. The status lock bit reads 0.
- R2: A write to address 0 turns on the gate of each gateable block whose data bit is 1. Gates under data bits that are 0 are unchanged. A read of address 0 returns `blk_clk_en`, with 1 meaning the clock is running.
- R3: A write to address 1 turns off the gate of each gateable block whose data bit is 1. Other gates are unchanged. A read of address 1 returns 0.
- R4: A write to address 2 loads the reset register. A 1 holds the block's `blk_rst` high and a 0 releases it, from the cycle after the write. A read of address 2 returns `blk_rst`.
- R5: A block whose GATE_CAP_MASK bit is 0 keeps its gate at 1 through every set and clear write. A block whose RST_CAP_MASK bit is 0 keeps `blk_rst` at 0 and reads 0.
- R6: Address 3 bits [2:0] hold the performance code, driven on `perf_mode`. Code 0 selects the highest-performance PLL mode and is the reset value. The code changes only when address 3 is written.
- R7: At address 3, bit 8 is the oscillator enable and bits 9 and 10 are the audio consumer selects, driven on `aud_osc_sel[1:0]`. Setting either select bit turns the oscillator on.
- R8: `osc_en` equals bit 8 OR bit 9 OR bit 10 of the last write to address 3. The oscillator stays on while one consumer still selects it, even if the write clears bit 8 and the other select. A read of address 3 returns the stored code, selects and the effective oscillator bit.
- R9: After any write to address 3, status bit 0 at address 4 (PLL locked) reads 0 for exactly LOCK_CYCLES cycles and then reads 1. A further write during the wait restarts the wait.
- R10: Writes to address 4 and to unmapped addresses 5 to 7 change no output. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write access |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| blk_clk_en | output | N_BLK | Per-block clock gate enable |
| blk_rst | output | N_BLK | Per-block reset, active high |
| osc_en | output | 1 | Shared oscillator power enable |
| aud_osc_sel | output | N_AUD | Per-consumer oscillator select |
| perf_mode | output | PERF_W | PLL performance code |

## Verification
The hardest case to reach is the shared-oscillator hand-off. The oscillator must outlive one consumer's deselection only while the other still selects it, and that depends on the order of writes, not on a single value. The stimulus walks all eight combinations of enable and the two selects in sequence, then runs an explicit drop-one-consumer-then-the-other sequence. The lock window is probed cycle by cycle through the status register. A second write lands mid-window to show that the wait restarts.

// File: rtl/ckrst_pkg.sv
`timescale 1ns/1ps
package ckrst_pkg;

  // Register word addresses
  localparam logic [2:0] RA_GATE_SET = 3'd0;
  localparam logic [2:0] RA_GATE_CLR = 3'd1;
  localparam logic [2:0] RA_RESET    = 3'd2;
  localparam logic [2:0] RA_CLKCTL   = 3'd3;
  localparam logic [2:0] RA_STATUS   = 3'd4;

  // Clock control field positions
  localparam int unsigned CC_OSC_BIT = 8;
  localparam int unsigned CC_SEL_LSB = 9;

  typedef struct packed {
    logic gate_set;
    logic gate_clr;
    logic rst_wr;
    logic clk_wr;
  } wr_strobe_t;

endpackage

// File: rtl/ckrst_regdec.sv
`timescale 1ns/1ps
module ckrst_regdec
  import ckrst_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] gate_rd,
  input  logic [DATA_W-1:0] rst_rd,
  input  logic [DATA_W-1:0] clk_rd,
  input  logic [DATA_W-1:0] stat_rd,
  output wr_strobe_t        stb,
  output logic [DATA_W-1:0] rdata
);

  logic wr_access;
  assign wr_access = bus_sel & bus_wr;

  always_comb begin
    stb = '0;
    if (wr_access) begin
      case (bus_addr)
        RA_GATE_SET: stb.gate_set = 1'b1;
        RA_GATE_CLR: stb.gate_clr = 1'b1;
        RA_RESET:    stb.rst_wr   = 1'b1;
        RA_CLKCTL:   stb.clk_wr   = 1'b1;
        default:     stb          = '0;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      RA_GATE_SET: rdata = gate_rd;
      RA_RESET:    rdata = rst_rd;
      RA_CLKCTL:   rdata = clk_rd;
      RA_STATUS:   rdata = stat_rd;
      default:     rdata = '0;
    endcase
  end

endmodule

// File: rtl/ckrst_gate_bank.sv
`timescale 1ns/1ps
module ckrst_gate_bank #(
  parameter int unsigned      N_BLK         = 16,
  parameter logic [N_BLK-1:0] GATE_CAP_MASK = '1,
  parameter logic [N_BLK-1:0] RST_CAP_MASK  = '1,
  parameter logic [N_BLK-1:0] ALWAYS_ON_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic             rst_stb,
  input  logic [N_BLK-1:0] wdata,
  output logic [N_BLK-1:0] gate_en,
  output logic [N_BLK-1:0] blk_rst
);

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk

    if (GATE_CAP_MASK[b]) begin : g_gate
      logic gate_q, gate_d, gate_ce;

      always_comb begin
        gate_ce = (set_stb | clr_stb) & wdata[b];
        gate_d  = set_stb;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gate_q <= ALWAYS_ON_MASK[b];
        else if (gate_ce) gate_q <= gate_d;
      end

      assign gate_en[b] = gate_q;
    end else begin : g_nogate
      assign gate_en[b] = 1'b1;
    end

    if (RST_CAP_MASK[b]) begin : g_rst
      logic rst_q, rst_d, rst_ce;

      always_comb begin
        rst_ce = rst_stb;
        rst_d  = wdata[b];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rst_q <= ~ALWAYS_ON_MASK[b];
        else if (rst_ce) rst_q <= rst_d;
      end

      assign blk_rst[b] = rst_q;
    end else begin : g_norst
      assign blk_rst[b] = 1'b0;
    end

  end

endmodule

// File: rtl/ckrst_clkctl.sv
`timescale 1ns/1ps
module ckrst_clkctl #(
  parameter int unsigned       PERF_W     = 3,
  parameter int unsigned       N_AUD      = 2,
  parameter logic [PERF_W-1:0] PERF_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [PERF_W-1:0] wr_perf,
  input  logic              wr_osc,
  input  logic [N_AUD-1:0]  wr_sel,
  output logic [PERF_W-1:0] perf_mode,
  output logic [N_AUD-1:0]  aud_sel,
  output logic              osc_en
);

  logic [PERF_W-1:0] perf_q, perf_d;
  logic [N_AUD-1:0]  sel_q, sel_d;
  logic              osc_q, osc_d;

  // A consumer that still selects the oscillator keeps it powered.
  always_comb begin
    perf_d = wr_perf;
    sel_d  = wr_sel;
    osc_d  = wr_osc | (|wr_sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perf_q <= PERF_RESET;
      sel_q  <= '0;
      osc_q  <= 1'b0;
    end else if (wr_stb) begin
      perf_q <= perf_d;
      sel_q  <= sel_d;
      osc_q  <= osc_d;
    end
  end

  assign perf_mode = perf_q;
  assign aud_sel   = sel_q;
  assign osc_en    = osc_q;

endmodule

// File: rtl/ckrst_lock_timer.sv
`timescale 1ns/1ps
module ckrst_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic locked
);

  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LOCK_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_ce = restart | (cnt_q != '0);
    cnt_d  = restart ? CNT_LOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_LOAD;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign locked = (cnt_q == '0);

endmodule

// File: rtl/ckrst_ctrl.sv
`timescale 1ns/1ps
module ckrst_ctrl
  import ckrst_pkg::*;
#(
  parameter int unsigned       N_BLK          = 16,
  parameter int unsigned       DATA_W         = 16,
  parameter int unsigned       PERF_W         = 3,
  parameter int unsigned       N_AUD          = 2,
  parameter int unsigned       LOCK_CYCLES    = 8,
  parameter logic [N_BLK-1:0]  GATE_CAP_MASK  = 16'hFF7F,
  parameter logic [N_BLK-1:0]  RST_CAP_MASK   = 16'hBFFF,
  parameter logic [N_BLK-1:0]  ALWAYS_ON_MASK = 16'h0001,
  parameter logic [PERF_W-1:0] PERF_RESET     = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_BLK-1:0]  blk_clk_en,
  output logic [N_BLK-1:0]  blk_rst,
  output logic              osc_en,
  output logic [N_AUD-1:0]  aud_osc_sel,
  output logic [PERF_W-1:0] perf_mode
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_q, rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  wr_strobe_t        stb;
  logic              pll_locked;
  logic [DATA_W-1:0] gate_rd, rst_rd, clk_rd, stat_rd;

  ckrst_gate_bank #(
    .N_BLK          (N_BLK),
    .GATE_CAP_MASK  (GATE_CAP_MASK),
    .RST_CAP_MASK   (RST_CAP_MASK),
    .ALWAYS_ON_MASK (ALWAYS_ON_MASK)
  ) i_gate_bank (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_stb (stb.gate_set),
    .clr_stb (stb.gate_clr),
    .rst_stb (stb.rst_wr),
    .wdata   (bus_wdata[N_BLK-1:0]),
    .gate_en (blk_clk_en),
    .blk_rst (blk_rst)
  );

  ckrst_clkctl #(
    .PERF_W     (PERF_W),
    .N_AUD      (N_AUD),
    .PERF_RESET (PERF_RESET)
  ) i_clkctl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .wr_stb    (stb.clk_wr),
    .wr_perf   (bus_wdata[PERF_W-1:0]),
    .wr_osc    (bus_wdata[CC_OSC_BIT]),
    .wr_sel    (bus_wdata[CC_SEL_LSB +: N_AUD]),
    .perf_mode (perf_mode),
    .aud_sel   (aud_osc_sel),
    .osc_en    (osc_en)
  );

  ckrst_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) i_lock_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .restart (stb.clk_wr),
    .locked  (pll_locked)
  );

  always_comb begin
    gate_rd                     = '0;
    gate_rd[N_BLK-1:0]          = blk_clk_en;
    rst_rd                      = '0;
    rst_rd[N_BLK-1:0]           = blk_rst;
    clk_rd                      = '0;
    clk_rd[PERF_W-1:0]          = perf_mode;
    clk_rd[CC_OSC_BIT]          = osc_en;
    clk_rd[CC_SEL_LSB +: N_AUD] = aud_osc_sel;
    stat_rd                     = '0;
    stat_rd[0]                  = pll_locked;
  end

  ckrst_regdec #(
    .DATA_W (DATA_W)
  ) i_regdec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .gate_rd  (gate_rd),
    .rst_rd   (rst_rd),
    .clk_rd   (clk_rd),
    .stat_rd  (stat_rd),
    .stb      (stb),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/ckrst_checker.sv
`timescale 1ns/1ps
module ckrst_checker
  import ckrst_pkg::*;
#(
  parameter int unsigned       N_BLK         = 16,
  parameter int unsigned       DATA_W        = 16,
  parameter int unsigned       PERF_W        = 3,
  parameter int unsigned       N_AUD         = 2,
  parameter logic [N_BLK-1:0]  GATE_CAP_MASK = '1,
  parameter logic [N_BLK-1:0]  RST_CAP_MASK  = '1
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_BLK-1:0]  blk_clk_en,
  input logic [N_BLK-1:0]  blk_rst,
  input logic              osc_en,
  input logic [N_AUD-1:0]  aud_osc_sel,
  input logic [PERF_W-1:0] perf_mode,
  input logic              pll_locked
);

  logic             wr_any;
  logic [N_BLK-1:0] wd;
  assign wr_any = bus_sel & bus_wr;
  assign wd     = bus_wdata[N_BLK-1:0];

  AST_GATE_SET_RAISES: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_any && bus_addr == RA_GATE_SET) |=>
      ((blk_clk_en & $past(wd)) == $past(wd)) &&
      ((blk_clk_en & ~$past(wd)) == ($past(blk_clk_en) & ~$past(wd)))); // R2

  AST_GATE_CLR_LOWERS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_any && bus_addr == RA_GATE_CLR) |=>
      ((blk_clk_en & $past(wd) & GATE_CAP_MASK) == '0) &&
      ((blk_clk_en & ~$past(wd)) == ($past(blk_clk_en) & ~$past(wd)))); // R3

  AST_RESET_LOADS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_any && bus_addr == RA_RESET) |=> (blk_rst == ($past(wd) & RST_CAP_MASK))); // R4

  AST_NOCAP_BLOCKS: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((blk_rst & ~RST_CAP_MASK) == '0) && ((blk_clk_en | GATE_CAP_MASK) == '1)); // R5

  AST_PERF_HOLDS: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(wr_any && bus_addr == RA_CLKCTL) |=> $stable(perf_mode)); // R6

  AST_OSC_COVERS_SEL: assert property (@(posedge clk) disable iff (!core_rst_n)
    (|aud_osc_sel) |-> osc_en); // R8

  AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_any && bus_addr == RA_CLKCTL) |=> !pll_locked); // R9

  AST_STATUS_WRITE_NOP: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_any && bus_addr >= RA_STATUS) |=>
      ($stable(blk_clk_en) && $stable(blk_rst) && $stable(osc_en) &&
       $stable(aud_osc_sel) && $stable(perf_mode))); // R10

endmodule

bind ckrst_ctrl ckrst_checker #(
  .N_BLK         (N_BLK),
  .DATA_W        (DATA_W),
  .PERF_W        (PERF_W),
  .N_AUD         (N_AUD),
  .GATE_CAP_MASK (GATE_CAP_MASK),
  .RST_CAP_MASK  (RST_CAP_MASK)
) i_ckrst_checker (
  .clk         (clk),
  .core_rst_n  (rst_core_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .blk_clk_en  (blk_clk_en),
  .blk_rst     (blk_rst),
  .osc_en      (osc_en),
  .aud_osc_sel (aud_osc_sel),
  .perf_mode   (perf_mode),
  .pll_locked  (pll_locked)
);

// File: tb/test_ckrst_ctrl.sv
`timescale 1ns/1ps
module test_ckrst_ctrl;

  localparam logic [15:0] GCAP = 16'hFF7F;
  localparam logic [15:0] RCAP = 16'hBFFF;
  localparam logic [15:0] AON  = 16'h0001;
  localparam int          LOCK = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [15:0] blk_clk_en, blk_rst;
  logic        osc_en;
  logic [1:0]  aud_osc_sel;
  logic [2:0]  perf_mode;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [15:0] mg, mr, mc;

  always #5 clk = ~clk;

  ckrst_ctrl i_ckrst_ctrl (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .blk_clk_en, .blk_rst, .osc_en, .aud_osc_sel, .perf_mode
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [15:0] clk_model(input logic [15:0] w);
    logic o;
    o = w[8] | w[9] | w[10];
    return (w & 16'h0607) | {7'b0, o, 8'b0};
  endfunction

  // Compare every output and readback with the bench model.
  task automatic chk_all(input string req);
    logic [15:0] d;
    chk(req, blk_clk_en, mg);
    chk(req, blk_rst, mr);
    rd(3'd0, d); chk(req, d, mg);
    rd(3'd2, d); chk(req, d, mr);
    rd(3'd3, d); chk(req, d, mc);
    chk(req, {osc_en, aud_osc_sel, perf_mode}, {mc[8], mc[10:9], mc[2:0]});
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    mg = AON | ~GCAP; mr = ~AON & RCAP; mc = 16'h0000;
    chk("R1 gate", blk_clk_en, 16'h0081);
    chk("R1 rst", blk_rst, 16'hBFFE);
    chk("R1 osc", {osc_en, aud_osc_sel, perf_mode}, 0);
    bus_addr = 3'd4; #1 chk("R1 lock", bus_rdata, 0);
    repeat (LOCK + 4) @(negedge clk);
    rd(3'd4, d); chk("R9 lock after reset", d, 1);

    // R2 R3 R5 walking set/clear over every block
    for (int b = 0; b < 16; b++) begin
      wr(3'd0, 16'(1) << b); mg = mg | (16'(1) << b);
      chk_all("R2 set walk");
      rd(3'd1, d); chk("R3 clr reads 0", d, 0);
      wr(3'd1, 16'(1) << b); mg = (mg & ~(16'(1) << b)) | ~GCAP;
      chk_all("R3 clr walk R5");
    end

    // R2 R3 patterns
    wr(3'd0, 16'hA5A5); mg = mg | 16'hA5A5; chk_all("R2 pattern A5A5");
    wr(3'd0, 16'h0F00); mg = mg | 16'h0F00; chk_all("R2 zero bits keep");
    wr(3'd1, 16'h00F0); mg = (mg & ~16'h00F0) | ~GCAP; chk_all("R3 partial clr");
    wr(3'd1, 16'hFFFF); mg = ~GCAP; chk_all("R3 R5 clr all");

    // R4 R5 reset register
    for (int b = 0; b < 16; b++) begin
      wr(3'd2, ~(16'(1) << b)); mr = ~(16'(1) << b) & RCAP; chk_all("R4 walk0");
    end
    wr(3'd2, 16'hFFFF); mr = RCAP; chk_all("R5 rst nocap");
    wr(3'd2, 16'h0000); mr = 0; chk_all("R4 release all");

    // R6 perf sweep
    for (int v = 7; v >= 0; v--) begin
      wr(3'd3, 16'(v)); mc = clk_model(16'(v)); chk_all("R6 perf");
    end

    // R7 R8 oscillator combinations
    for (int c = 0; c < 8; c++) begin
      wr(3'd3, 16'(c) << 8); mc = clk_model(16'(c) << 8); chk_all("R7 R8 osc combo");
    end
    wr(3'd3, 16'h0700); mc = clk_model(16'h0700); chk_all("R7 both on");
    wr(3'd3, 16'h0400); mc = clk_model(16'h0400);
    chk("R8 osc kept by sel1", osc_en, 1'b1); chk_all("R8 drop one");
    wr(3'd3, 16'h0000); mc = 0;
    chk("R8 osc off", osc_en, 1'b0); chk_all("R8 drop both");

    // R9 exact lock window and restart
    wr(3'd3, 16'h0002); mc = clk_model(16'h0002);
    bus_addr = 3'd4;
    for (int j = 0; j < LOCK; j++) begin
      #1 chk("R9 lock low", bus_rdata[0], 1'b0);
      @(negedge clk);
    end
    #1 chk("R9 lock high", bus_rdata[0], 1'b1);
    wr(3'd3, 16'h0003); mc = clk_model(16'h0003);
    repeat (3) @(negedge clk);
    wr(3'd3, 16'h0001); mc = clk_model(16'h0001);
    bus_addr = 3'd4;
    for (int j = 0; j < LOCK; j++) begin
      #1 chk("R9 restart low", bus_rdata[0], 1'b0);
      @(negedge clk);
    end
    #1 chk("R9 restart high", bus_rdata[0], 1'b1);

    // R10 status and unmapped writes
    wr(3'd0, 16'h1234); mg = mg | 16'h1234;
    wr(3'd2, 16'h4321); mr = 16'h4321 & RCAP;
    for (int a = 4; a < 8; a++) begin
      wr(3'(a), 16'hFFFF); chk_all("R10 ignored write");
    end
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), d); chk("R10 unmapped read", d, 0);
    end
    rd(3'd4, d); chk("R10 status", d, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule